// File: doc/BRIEF.md
# Word-to-byte register bus bridge

This block sits behind a 32-bit Wishbone classic slave port and reaches a register bank that speaks an 8-bit strobe-based register bus. Every Wishbone word access is split into one byte-wide register cycle per byte lane. An internal step counter walks the lanes from the lowest to the highest. For each selected lane the bridge puts out the byte address, a read or write strobe and, for writes, the byte of write data. Read bytes come back one clock after their strobe and are gathered into the Wishbone read word. When all lanes have been visited the bridge answers with a single-cycle ACK.

The sequencer is designed so that every selected register location is touched exactly once per Wishbone transaction. A master may keep CYC and STB high for a clock or more after it has seen ACK. The bridge then waits until STB or CYC has been seen low before it accepts the next access. Because a read of a register can have side effects, this rule matters.

Top module: `wbcsr_bridge`

## Requirements
- R1: While reset is active, and in the first idle cycle after it, `wb_ack`, `csr_rd` and `csr_wr` are low and `wb_dat_r` is zero.
- R2: With CYC and STB first seen high in cycle 0 of an idle bridge, lane k (k = 0 to 3) is served in cycle k, in ascending order. The byte address is `{wb_adr, k}`, so lane k is register address 4*wb_adr + k.
- R3: A lane is strobed only when its `wb_sel` bit is set. Reads use `csr_rd` only and writes use `csr_wr` only, and the two are never high together. Unselected lanes are skipped, but their cycle still passes.
- R4: In the write cycle of lane k, `csr_wdata` carries bits [8k+7:8k] of `wb_dat_w`.
- R5: Byte data on `csr_rdata` is taken in the cycle after the read strobe of lane k and lands in bits [8k+7:8k] of `wb_dat_r`. Lanes not selected read back as zero.
- R6: `wb_ack` is high in cycle 5 only, counting from cycle 0 of R2. It is a one-cycle pulse, and exactly one ACK is given per transaction, whether or not any lane is selected.
- R7: In the ACK cycle, and in every following cycle while CYC and STB stay high, no strobe is issued. Each selected location therefore sees exactly one strobe per transaction.
- R8: If CYC or STB drops before ACK, the access is abandoned with no ACK. The next access starts again at lane 0.
- R9: STB high while CYC is low starts no register cycle and gives no ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wb_cyc | input | 1 | Wishbone bus cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 2 | Wishbone word address |
| wb_sel | input | 4 | byte lane selects, bit k for lane k |
| wb_dat_w | input | 32 | Wishbone write data |
| wb_dat_r | output | 32 | Wishbone read data |
| wb_ack | output | 1 | one-cycle acknowledge |
| csr_addr | output | 4 | register byte address |
| csr_rd | output | 1 | register read strobe |
| csr_wr | output | 1 | register write strobe |
| csr_wdata | output | 8 | register write byte |
| csr_rdata | input | 8 | register read byte, valid one clock after `csr_rd` |

## Verification
The assertions assume a Wishbone classic master that keeps `wb_adr`, `wb_we`, `wb_sel` and `wb_dat_w` steady while CYC and STB are high. They also assume the register side returns its byte exactly one clock after the read strobe. The stimulus changes the request fields only while STB is low, and it models the register bank as a byte array with that one-clock read latency. Outside a read cycle the model drives a fixed filler byte, so a capture taken at the wrong time shows up as wrong data. The stimulus also keeps STB high for zero, one and two cycles after ACK, abandons an access part way through, and raises STB without CYC.

// File: rtl/wbcsr_pkg.sv
package wbcsr_pkg;

    // Phases of the lane sequencer.
    typedef enum logic [1:0] {
        SEQ_STEP = 2'd0,   // walking the byte lanes, or idle with count zero
        SEQ_ACK  = 2'd1,   // acknowledge cycle
        SEQ_WAIT = 2'd2    // master still holds strobe after acknowledge
    } seq_phase_e;

endpackage

// File: rtl/wbcsr_seq.sv
module wbcsr_seq
    import wbcsr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_act,
    output logic                      access_en,
    output logic                      first_lane,
    output logic [$clog2(LANES)-1:0]  lane,
    output logic                      ack
);
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = LANE_W + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LANES);

    typedef struct packed {
        seq_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            SEQ_STEP: begin
                if (!bus_act) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt == LAST_CNT) begin
                    s_d.phase = SEQ_ACK;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_ACK: begin
                s_d.cnt   = '0;
                s_d.phase = bus_act ? SEQ_WAIT : SEQ_STEP;
            end
            SEQ_WAIT: begin
                s_d.cnt = '0;
                if (!bus_act) begin
                    s_d.phase = SEQ_STEP;
                end
            end
            default: begin
                s_d.phase = SEQ_STEP;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= SEQ_STEP;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign access_en  = (s_q.phase == SEQ_STEP) && bus_act && (s_q.cnt < LAST_CNT);
    assign first_lane = access_en && (s_q.cnt == '0);
    assign lane       = s_q.cnt[LANE_W-1:0];
    assign ack        = (s_q.phase == SEQ_ACK);

endmodule

// File: rtl/wbcsr_lane_drv.sv
module wbcsr_lane_drv #(
    parameter int LANES      = 4,
    parameter int CSR_DATA_W = 8,
    parameter int CSR_ADDR_W = 4
) (
    input  logic                                  access_en,
    input  logic [$clog2(LANES)-1:0]              lane,
    input  logic                                  wb_we,
    input  logic [CSR_ADDR_W-$clog2(LANES)-1:0]   wb_adr,
    input  logic [LANES-1:0]                      wb_sel,
    input  logic [LANES*CSR_DATA_W-1:0]           wb_dat_w,
    output logic [CSR_ADDR_W-1:0]                 csr_addr,
    output logic                                  csr_rd,
    output logic                                  csr_wr,
    output logic [CSR_DATA_W-1:0]                 csr_wdata
);
    logic [LANES-1:0][CSR_DATA_W-1:0] wbytes;
    logic                             lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_wlane
        assign wbytes[g] = wb_dat_w[g*CSR_DATA_W +: CSR_DATA_W];
    end

    always_comb begin
        lane_hit  = access_en && wb_sel[lane];
        csr_addr  = {wb_adr, lane};
        csr_rd    = lane_hit && !wb_we;
        csr_wr    = lane_hit && wb_we;
        csr_wdata = wbytes[lane];
    end

endmodule

// File: rtl/wbcsr_rd_gather.sv
module wbcsr_rd_gather #(
    parameter int LANES      = 4,
    parameter int CSR_DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              first_lane,
    input  logic                              rd_fire,
    input  logic [$clog2(LANES)-1:0]          lane,
    input  logic [CSR_DATA_W-1:0]             csr_rdata,
    output logic [LANES*CSR_DATA_W-1:0]       rd_word
);
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic                              pend;
        logic [LANE_W-1:0]                 lane;
        logic [LANES-1:0][CSR_DATA_W-1:0]  data;
    } gather_t;

    gather_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.pend = rd_fire;
        g_d.lane = lane;
        if (first_lane) begin
            g_d.data = '0;
        end
        if (g_q.pend) begin
            g_d.data[g_q.lane] = csr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign rd_word = g_q.data;

endmodule

// File: rtl/wbcsr_bridge.sv
module wbcsr_bridge #(
    parameter int WB_DATA_W  = 32,
    parameter int CSR_DATA_W = 8,
    parameter int CSR_ADDR_W = 4,
    localparam int LANES     = WB_DATA_W / CSR_DATA_W,
    localparam int LANE_W    = $clog2(LANES),
    localparam int WB_ADDR_W = CSR_ADDR_W - LANE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_cyc,
    input  logic                  wb_stb,
    input  logic                  wb_we,
    input  logic [WB_ADDR_W-1:0]  wb_adr,
    input  logic [LANES-1:0]      wb_sel,
    input  logic [WB_DATA_W-1:0]  wb_dat_w,
    output logic [WB_DATA_W-1:0]  wb_dat_r,
    output logic                  wb_ack,
    output logic [CSR_ADDR_W-1:0] csr_addr,
    output logic                  csr_rd,
    output logic                  csr_wr,
    output logic [CSR_DATA_W-1:0] csr_wdata,
    input  logic [CSR_DATA_W-1:0] csr_rdata
);
    logic              bus_act;
    logic              access_en;
    logic              first_lane;
    logic [LANE_W-1:0] lane;
    logic              rd_strobe;

    assign bus_act = wb_cyc && wb_stb;

    wbcsr_seq #(
        .LANES (LANES)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_act    (bus_act),
        .access_en  (access_en),
        .first_lane (first_lane),
        .lane       (lane),
        .ack        (wb_ack)
    );

    wbcsr_lane_drv #(
        .LANES      (LANES),
        .CSR_DATA_W (CSR_DATA_W),
        .CSR_ADDR_W (CSR_ADDR_W)
    ) drv_i (
        .access_en (access_en),
        .lane      (lane),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_sel    (wb_sel),
        .wb_dat_w  (wb_dat_w),
        .csr_addr  (csr_addr),
        .csr_rd    (rd_strobe),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata)
    );

    assign csr_rd = rd_strobe;

    wbcsr_rd_gather #(
        .LANES      (LANES),
        .CSR_DATA_W (CSR_DATA_W)
    ) gather_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_lane (first_lane),
        .rd_fire    (rd_strobe),
        .lane       (lane),
        .csr_rdata  (csr_rdata),
        .rd_word    (wb_dat_r)
    );

endmodule

// File: rtl/wbcsr_bridge_chk.sv
module wbcsr_bridge_chk #(
    parameter int LANES      = 4,
    parameter int CSR_ADDR_W = 4,
    localparam int LANE_W    = $clog2(LANES),
    localparam int WB_ADDR_W = CSR_ADDR_W - LANE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wb_cyc,
    input logic                  wb_stb,
    input logic                  wb_we,
    input logic [WB_ADDR_W-1:0]  wb_adr,
    input logic [LANES-1:0]      wb_sel,
    input logic                  wb_ack,
    input logic [CSR_ADDR_W-1:0] csr_addr,
    input logic                  csr_rd,
    input logic                  csr_wr
);
    p_addr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd || csr_wr) |-> (csr_addr[CSR_ADDR_W-1:LANE_W] == wb_adr));

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rd && csr_wr));

    p_rd_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |-> (!wb_we && wb_sel[csr_addr[LANE_W-1:0]]));

    p_wr_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |-> (wb_we && wb_sel[csr_addr[LANE_W-1:0]]));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    p_ack_after_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_cyc && wb_stb));

    p_quiet_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> !(csr_rd || csr_wr));

    p_quiet_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !(csr_rd || csr_wr));

    p_idle_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_cyc && wb_stb) |-> !(csr_rd || csr_wr));

endmodule

bind wbcsr_bridge wbcsr_bridge_chk #(
    .LANES      (LANES),
    .CSR_ADDR_W (CSR_ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_sel   (wb_sel),
    .wb_ack   (wb_ack),
    .csr_addr (csr_addr),
    .csr_rd   (csr_rd),
    .csr_wr   (csr_wr)
);

// File: tb/wbcsr_bridge_tb_top.sv
`timescale 1ns/1ps
module wbcsr_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0;
    logic        wb_stb = 1'b0;
    logic        wb_we = 1'b0;
    logic [1:0]  wb_adr = '0;
    logic [3:0]  wb_sel = '0;
    logic [31:0] wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;
    logic [3:0]  csr_addr;
    logic        csr_rd;
    logic        csr_wr;
    logic [7:0]  csr_wdata;
    logic [7:0]  csr_rdata = 8'hEE;

    always #10 clk = ~clk;

    wbcsr_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_sel    (wb_sel),
        .wb_dat_w  (wb_dat_w),
        .wb_dat_r  (wb_dat_r),
        .wb_ack    (wb_ack),
        .csr_addr  (csr_addr),
        .csr_rd    (csr_rd),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata)
    );

    // register bank model and strobe monitor
    logic [7:0] mem [16];
    int         rd_tot [16];
    int         wr_tot [16];
    int         ack_tot = 0;
    int         ord_bad = 0;
    int         last_lane = -1;

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 8'h00; rd_tot[i] = 0; wr_tot[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            csr_rdata <= csr_rd ? mem[csr_addr] : 8'hEE;
            if (csr_wr) mem[csr_addr] <= csr_wdata;
            if (csr_rd) rd_tot[csr_addr] <= rd_tot[csr_addr] + 1;
            if (csr_wr) wr_tot[csr_addr] <= wr_tot[csr_addr] + 1;
            if (wb_ack) ack_tot <= ack_tot + 1;
            if (wb_ack || !(wb_cyc && wb_stb)) begin
                last_lane <= -1;
            end else if (csr_rd || csr_wr) begin
                if (int'(csr_addr[1:0]) <= last_lane) ord_bad <= ord_bad + 1;
                last_lane <= int'(csr_addr[1:0]);
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [7:0] exp_mem [16];
    int rd_snap [16];
    int wr_snap [16];
    int ack_snap;
    int ord_snap;

    task automatic snap();
        for (int i = 0; i < 16; i++) begin
            rd_snap[i] = rd_tot[i]; wr_snap[i] = wr_tot[i];
        end
        ack_snap = ack_tot;
        ord_snap = ord_bad;
    endtask

    task automatic run_txn(input logic we, input logic [1:0] adr, input logic [3:0] sel,
                           input logic [31:0] wd, input int extra,
                           output logic [31:0] rd, output int lat);
        snap();
        @(negedge clk);
        wb_we = we; wb_adr = adr; wb_sel = sel; wb_dat_w = wd;
        wb_cyc = 1'b1; wb_stb = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!wb_ack && lat < 20);
        rd = wb_dat_r;
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            chk(!wb_ack, "R6", "ack held past one cycle", {31'd0, wb_ack}, 32'd0);
        end
        wb_cyc = 1'b0; wb_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  adr;
        logic [3:0]  sel;
        logic [31:0] wd;
        logic [1:0]  extra;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 2'd0, 4'hF, 32'h44332211, 2'd1},
        '{1'b0, 2'd0, 4'h1, 32'h00000000, 2'd1},
        '{1'b0, 2'd0, 4'hF, 32'h00000000, 2'd0},
        '{1'b1, 2'd1, 4'h5, 32'hA1B2C3D4, 2'd2},
        '{1'b0, 2'd1, 4'hF, 32'h00000000, 2'd1},
        '{1'b1, 2'd3, 4'h8, 32'h9E000000, 2'd0},
        '{1'b0, 2'd3, 4'hA, 32'h00000000, 2'd2},
        '{1'b1, 2'd2, 4'h0, 32'hFFFFFFFF, 2'd1},
        '{1'b0, 2'd2, 4'hF, 32'h00000000, 2'd1},
        '{1'b0, 2'd1, 4'h6, 32'h00000000, 2'd2}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_rd;
        int lat;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!wb_ack, "R1", "ack in reset", {31'd0, wb_ack}, 32'd0);
        chk(!csr_rd && !csr_wr, "R1", "strobes in reset", {30'd0, csr_rd, csr_wr}, 32'd0);
        chk(wb_dat_r == 32'd0, "R1", "read word in reset", wb_dat_r, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wb_ack && !csr_rd && !csr_wr && wb_dat_r == 32'd0, "R1", "idle after reset",
            {wb_dat_r[31:3], wb_ack, csr_rd, csr_wr}, 32'd0);

        // table walk
        foreach (VECS[v]) begin
            run_txn(VECS[v].we, VECS[v].adr, VECS[v].sel, VECS[v].wd, int'(VECS[v].extra), rd, lat);
            chk(lat == 5, "R6", "ack cycle", lat, 32'd5);
            chk(ack_tot - ack_snap == 1, "R6", "acks per transaction", ack_tot - ack_snap, 32'd1);
            chk(ord_bad == ord_snap, "R2", "lane order", ord_bad - ord_snap, 32'd0);
            exp_rd = '0;
            for (int k = 0; k < 4; k++) begin
                int a;
                a = {VECS[v].adr, 2'(k)};
                if (VECS[v].we) begin
                    chk(wr_tot[a] - wr_snap[a] == int'(VECS[v].sel[k]), "R7",
                        "write strobes per lane", wr_tot[a] - wr_snap[a], {31'd0, VECS[v].sel[k]});
                    chk(rd_tot[a] == rd_snap[a], "R3", "read strobe during write",
                        rd_tot[a] - rd_snap[a], 32'd0);
                    if (VECS[v].sel[k]) exp_mem[a] = VECS[v].wd[k*8 +: 8];
                    chk(mem[a] == exp_mem[a], "R4", "written byte", {24'd0, mem[a]}, {24'd0, exp_mem[a]});
                end else begin
                    chk(rd_tot[a] - rd_snap[a] == int'(VECS[v].sel[k]), "R7",
                        "read strobes per lane", rd_tot[a] - rd_snap[a], {31'd0, VECS[v].sel[k]});
                    chk(wr_tot[a] == wr_snap[a], "R3", "write strobe during read",
                        wr_tot[a] - wr_snap[a], 32'd0);
                    if (VECS[v].sel[k]) exp_rd[k*8 +: 8] = exp_mem[a];
                end
            end
            if (!VECS[v].we) chk(rd == exp_rd, "R5", "read word", rd, exp_rd);
        end

        // R8: abandon after two lanes, then a fresh access restarts at lane 0
        snap();
        @(negedge clk);
        wb_we = 1'b0; wb_adr = 2'd1; wb_sel = 4'hF; wb_cyc = 1'b1; wb_stb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wb_stb = 1'b0; wb_cyc = 1'b0;
        repeat (4) @(negedge clk);
        chk(ack_tot == ack_snap, "R8", "ack after abandon", ack_tot - ack_snap, 32'd0);
        chk(rd_tot[4] - rd_snap[4] == 1 && rd_tot[5] - rd_snap[5] == 1 &&
            rd_tot[6] == rd_snap[6] && rd_tot[7] == rd_snap[7], "R8", "lanes read before abandon",
            {rd_tot[4] - rd_snap[4], rd_tot[5] - rd_snap[5], rd_tot[6] - rd_snap[6]}, 32'h10001);
        run_txn(1'b0, 2'd1, 4'hF, 32'd0, 1, rd, lat);
        chk(lat == 5, "R8", "restart ack cycle", lat, 32'd5);
        chk(rd_tot[4] - rd_snap[4] == 1 && rd_tot[7] - rd_snap[7] == 1, "R8",
            "restart reads all lanes", rd_tot[4] - rd_snap[4], 32'd1);
        chk(rd == {exp_mem[7], exp_mem[6], exp_mem[5], exp_mem[4]}, "R5", "read after restart",
            rd, {exp_mem[7], exp_mem[6], exp_mem[5], exp_mem[4]});

        // R9: strobe without cycle
        snap();
        @(negedge clk);
        wb_we = 1'b1; wb_adr = 2'd0; wb_sel = 4'hF; wb_dat_w = 32'hDEADBEEF;
        wb_cyc = 1'b0; wb_stb = 1'b1;
        repeat (7) begin
            @(negedge clk);
            chk(!csr_rd && !csr_wr && !wb_ack, "R9", "activity without CYC",
                {29'd0, csr_rd, csr_wr, wb_ack}, 32'd0);
        end
        wb_stb = 1'b0;
        @(negedge clk);
        chk(mem[0] == exp_mem[0] && mem[3] == exp_mem[3], "R9", "bank untouched",
            {24'd0, mem[0]}, {24'd0, exp_mem[0]});

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule